// File: doc/BRIEF.md
# Pulse-Train Waveform Transmitter

This block plays a waveform out of a small local item RAM onto a single output pin. Every 32-bit item carries two halves, and each half gives an output level and a duration. The duration is counted in ticks, and a programmable clock divider sets the length of a tick. Playback begins at the current read pointer when a start pulse arrives. It ends at the first half whose duration is zero, and the block then reports the end with a one-cycle event.

A threshold event fires when the read pointer reaches a programmed item index, and playback continues through it. Software can use this event to refill the half of the RAM that has already played while the other half is still running, so the RAM works as a ping-pong buffer. In continuous mode playback returns to item 0, both at a terminator and at the end of the configured span, until continuous mode is cleared. The block can also gate one output level with a carrier whose high and low periods are programmable. Between transmissions the pin drives a chosen idle level, or holds its last level.

Top module: `pulse_tx`

## Requirements
- R1: After reset `busy`, `thr_evt` and `tx_end` are low, and the pin shows the idle level when idle drive is enabled.
- R2: Item bits 15:0 form the first half and bits 31:16 the second half. In each half, bit 15 (or 31) is the level and bits 14:0 (or 30:16) are the duration. The first level appears in the cycle after the edge that samples `tx_start`. Each half holds its level for duration × N clock cycles.
- R3: The tick length N equals `cfg_div` for values 1 to 255, and a `cfg_div` of 0 gives N = 256.
- R4: A half with duration zero ends playback. `tx_end` pulses for one cycle, and `busy` drops in that same cycle. That cycle starts exactly (sum of the played durations) × N edges after the start edge. A start on an item whose first half has duration zero gives `tx_end` in the next cycle and drives no waveform.
- R5: While not busy, the pin drives `cfg_idle_lvl` when `cfg_idle_en` is 1. When `cfg_idle_en` is 0, the pin keeps the level of the last half played.
- R6: With the carrier enabled, halves whose level equals `cfg_car_on` drive the carrier on the pin. The carrier restarts at each start. It is high for `cfg_car_hi` cycles and then low for `cfg_car_lo` cycles, repeating. Halves at the other level pass through unchanged.
- R7: When `cfg_lim` is non-zero, `thr_evt` pulses for one cycle as the pointer moves onto item `cfg_lim`, and playback continues. A `cfg_lim` of 0 gives no event.
- R8: The span is `cfg_span` × 64 items. A span of 0 counts as 1, and a span above 2 counts as 2. In one-shot mode, playback stops after the last item of the span with `tx_end`, and the pointer returns to 0.
- R9: When `cfg_conti` is 1, a terminator or the end of the span restarts playback at item 0 without `tx_end`. After `cfg_conti` is cleared, the next terminator or span end finishes playback.
- R10: `rd_rst` in an idle cycle returns the pointer to item 0. A start without `rd_rst` resumes from the item on which the previous playback stopped.
- R11: `tx_start` and `rd_rst` have no effect while `busy` is high.
- R12: A RAM write takes effect at the next clock edge. This holds during playback too, so an item not yet reached plays with its new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Item RAM write strobe |
| wr_addr | input | 7 | Item RAM write index |
| wr_data | input | 32 | Item written |
| cfg_div | input | 8 | Tick divider, 0 means 256 |
| cfg_span | input | 2 | Number of 64-item blocks in the span |
| cfg_conti | input | 1 | Continuous (wrap-around) mode |
| cfg_lim | input | 7 | Threshold item index, 0 disables |
| cfg_car_en | input | 1 | Carrier enable |
| cfg_car_on | input | 1 | Level on which the carrier is applied |
| cfg_car_hi | input | 16 | Carrier high period in clocks |
| cfg_car_lo | input | 16 | Carrier low period in clocks |
| cfg_idle_en | input | 1 | Drive the idle level while not busy |
| cfg_idle_lvl | input | 1 | Idle level |
| tx_start | input | 1 | Start playback at the read pointer |
| rd_rst | input | 1 | Return the read pointer to item 0 |
| pin_out | output | 1 | Waveform output |
| busy | output | 1 | Playback in progress |
| thr_evt | output | 1 | Threshold event pulse |
| tx_end | output | 1 | End-of-transmission pulse |

## Verification
The bench counts edges from the edge that samples `tx_start`, which it calls k = 0. It then samples pin, `thr_evt` and `tx_end` after each later edge, away from that edge. For every run, the expected waveform at step k, the step at which `thr_evt` occurs and the step at which `tx_end` arrives are derived from the item durations × N. The first level is due at k = 0, and `tx_end` is due at k = total ticks × N. An immediate terminator is therefore expected at k = 0. Stimulus arriving during a run (a stray start, a reset of the pointer, a RAM write, clearing continuous mode) is applied at a fixed k, so that its effect, or its absence, lands in a known cycle.

// File: rtl/pulse_tx_pkg.sv
package pulse_tx_pkg;
  localparam int DUR_W = 15;

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } half_t;

  typedef struct packed {
    half_t hi_half;
    half_t lo_half;
  } item_t;
endpackage

// File: rtl/pulse_tx_mem.sv
module pulse_tx_mem
  import pulse_tx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  item_t         wr_item,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] nxt_addr,
  output item_t         cur_item,
  output half_t         nxt_first,
  output half_t         base_first
);
  item_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_item;
  end

  assign cur_item   = store[cur_addr];
  assign nxt_first  = store[nxt_addr].lo_half;
  assign base_first = store[0].lo_half;
endmodule

// File: rtl/pulse_tx_tick.sv
module pulse_tx_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d, reload;

  assign reload = div - 1'b1;
  assign tick   = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = reload;
    else if (run)  cnt_d = tick ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pulse_tx_carrier.sv
module pulse_tx_carrier #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [PW-1:0] hi_len,
  input  logic [PW-1:0] lo_len,
  output logic          phase
);
  logic          ph_q, ph_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW:0]   span, nxt;

  assign span  = {1'b0, (ph_q ? hi_len : lo_len)};
  assign nxt   = {1'b0, cnt_q} + 1'b1;
  assign phase = ph_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (restart) begin
      ph_d  = 1'b1;
      cnt_d = '0;
    end else if (run) begin
      if (nxt >= span) begin
        ph_d  = ~ph_q;
        cnt_d = '0;
      end else begin
        cnt_d = nxt[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pulse_tx.sv
module pulse_tx
  import pulse_tx_pkg::*;
#(
  parameter int BLK_ITEMS = 64,
  parameter int MAX_BLKS  = 2,
  parameter int DIV_W     = 8,
  parameter int CAR_W     = 16,
  localparam int DEPTH    = BLK_ITEMS * MAX_BLKS,
  localparam int AW       = $clog2(DEPTH),
  localparam int SPW      = $clog2(MAX_BLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [SPW-1:0]   cfg_span,
  input  logic             cfg_conti,
  input  logic [AW-1:0]    cfg_lim,
  input  logic             cfg_car_en,
  input  logic             cfg_car_on,
  input  logic [CAR_W-1:0] cfg_car_hi,
  input  logic [CAR_W-1:0] cfg_car_lo,
  input  logic             cfg_idle_en,
  input  logic             cfg_idle_lvl,
  input  logic             tx_start,
  input  logic             rd_rst,
  output logic             pin_out,
  output logic             busy,
  output logic             thr_evt,
  output logic             tx_end
);
  // synchronous release of the asynchronous reset
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // sequencer state
  logic             busy_q, busy_d, half_q, half_d, lvl_q, lvl_d;
  logic             end_q, end_d, thr_q, thr_d;
  logic [AW-1:0]    ptr_q, ptr_d, nxt_ptr, cptr, last_idx;
  logic [DUR_W-1:0] rem_q, rem_d;
  logic             tick, car_ph, restart, at_last;
  item_t            rd_cur;
  half_t            rd_nxt, rd_base, cand, src;
  int               span_i;

  always_comb begin
    span_i = int'(cfg_span);
    if (span_i == 0)             span_i = 1;
    else if (span_i > MAX_BLKS)  span_i = MAX_BLKS;
    last_idx = AW'(span_i * BLK_ITEMS - 1);
  end

  assign at_last = (ptr_q == last_idx);
  assign nxt_ptr = at_last ? '0 : ptr_q + 1'b1;
  assign restart = !busy_q && busy_d;

  pulse_tx_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_item(item_t'(wr_data)),
    .cur_addr(ptr_q), .nxt_addr(nxt_ptr),
    .cur_item(rd_cur), .nxt_first(rd_nxt), .base_first(rd_base)
  );

  pulse_tx_tick #(.DW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .run(busy_q),
    .div(cfg_div), .tick(tick)
  );

  pulse_tx_carrier #(.PW(CAR_W)) u_car (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .run(busy_q),
    .hi_len(cfg_car_hi), .lo_len(cfg_car_lo), .phase(car_ph)
  );

  always_comb begin
    busy_d = busy_q;
    half_d = half_q;
    ptr_d  = ptr_q;
    rem_d  = rem_q;
    lvl_d  = lvl_q;
    end_d  = 1'b0;
    thr_d  = 1'b0;
    cand   = half_q ? rd_nxt : rd_cur.hi_half;
    cptr   = half_q ? nxt_ptr : ptr_q;
    src    = rd_rst ? rd_base : rd_cur.lo_half;
    if (!busy_q) begin
      if (rd_rst) ptr_d = '0;
      if (tx_start) begin
        if (src.dur == '0) begin
          end_d = 1'b1;
        end else begin
          busy_d = 1'b1;
          half_d = 1'b0;
          rem_d  = src.dur;
          lvl_d  = src.lvl;
        end
      end
    end else if (tick) begin
      if (rem_q != DUR_W'(1)) begin
        rem_d = rem_q - 1'b1;
      end else if (half_q && at_last && !cfg_conti) begin
        busy_d = 1'b0;
        end_d  = 1'b1;
        ptr_d  = '0;
      end else if (cand.dur != '0) begin
        half_d = ~half_q;
        ptr_d  = cptr;
        rem_d  = cand.dur;
        lvl_d  = cand.lvl;
        thr_d  = half_q && (cfg_lim != '0) && (cptr == cfg_lim);
      end else if (cfg_conti && rd_base.dur != '0) begin
        half_d = 1'b0;
        ptr_d  = '0;
        rem_d  = rd_base.dur;
        lvl_d  = rd_base.lvl;
      end else begin
        busy_d = 1'b0;
        end_d  = 1'b1;
        ptr_d  = cptr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      ptr_q  <= '0;
      rem_q  <= '0;
      lvl_q  <= 1'b0;
      end_q  <= 1'b0;
      thr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      ptr_q  <= ptr_d;
      rem_q  <= rem_d;
      lvl_q  <= lvl_d;
      end_q  <= end_d;
      thr_q  <= thr_d;
    end
  end

  logic run_lvl;
  assign run_lvl = (cfg_car_en && (lvl_q == cfg_car_on)) ? car_ph : lvl_q;
  assign pin_out = busy_q ? run_lvl : (cfg_idle_en ? cfg_idle_lvl : lvl_q);
  assign busy    = busy_q;
  assign thr_evt = thr_q;
  assign tx_end  = end_q;
endmodule

// File: rtl/pulse_tx_chk.sv
module pulse_tx_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          tx_end,
  input logic          thr_evt,
  input logic          tx_start,
  input logic          rd_rst,
  input logic [AW-1:0] ptr
);
  // R4: the end pulse never coexists with an active run
  p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> !busy);

  // R4: every drop of busy is announced by the end pulse
  p_fall_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_end);

  // R2: a run only begins from a start request
  p_rise_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_start));

  // R7: the threshold event occurs only mid-run, and the run continues
  p_thr_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |-> (busy && $past(busy)));

  // R10: pointer reset while idle lands on item 0
  p_ptr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_rst) |=> (ptr == '0));
endmodule

bind pulse_tx pulse_tx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .tx_end(end_q), .thr_evt(thr_q),
  .tx_start(tx_start), .rd_rst(rd_rst), .ptr(ptr_q)
);

// File: tb/pulse_tx_tb.sv
module pulse_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cfg_conti, cfg_car_en, cfg_car_on, cfg_idle_en, cfg_idle_lvl;
  logic        tx_start, rd_rst;
  logic [6:0]  wr_addr, cfg_lim;
  logic [31:0] wr_data;
  logic [7:0]  cfg_div;
  logic [1:0]  cfg_span;
  logic [15:0] cfg_car_hi, cfg_car_lo;
  logic        pin_out, busy, thr_evt, tx_end;

  int n_chk = 0;
  int n_fail = 0;
  bit ptrace [1100];

  always #5 clk = ~clk;

  pulse_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_div(cfg_div), .cfg_span(cfg_span), .cfg_conti(cfg_conti), .cfg_lim(cfg_lim),
    .cfg_car_en(cfg_car_en), .cfg_car_on(cfg_car_on), .cfg_car_hi(cfg_car_hi),
    .cfg_car_lo(cfg_car_lo), .cfg_idle_en(cfg_idle_en), .cfg_idle_lvl(cfg_idle_lvl),
    .tx_start(tx_start), .rd_rst(rd_rst), .pin_out(pin_out), .busy(busy),
    .thr_evt(thr_evt), .tx_end(tx_end)
  );

  // div, item, expected edges to tx_end, expected first level
  localparam logic [56:0] VEC [5] = '{
    {8'd1, 32'h0003_8005, 16'd8,   1'b1},
    {8'd4, 32'h0002_8003, 16'd20,  1'b1},
    {8'd0, 32'h0001_8001, 16'd512, 1'b1},
    {8'd3, 32'h8000_0004, 16'd12,  1'b0},
    {8'd2, 32'h0000_0000, 16'd0,   1'b0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ptr_rst();
    @(negedge clk); rd_rst = 1'b1;
    @(negedge clk); rd_rst = 1'b0;
  endtask

  task automatic measure(input int poke_at, input int wr_at, input int cc_at,
                         output int k, output int thr_n, output int thr_first);
    @(negedge clk); tx_start = 1'b1;
    @(posedge clk);
    @(negedge clk); tx_start = 1'b0;
    k = 0; thr_n = 0; thr_first = -1;
    while (!tx_end && k < 1099) begin
      ptrace[k] = pin_out;
      if (thr_evt) begin
        thr_n++;
        if (thr_first < 0) thr_first = k;
      end
      if (k == poke_at) begin tx_start = 1'b1; rd_rst = 1'b1; end
      if (k == wr_at) wr_en = 1'b1;
      if (k == cc_at) cfg_conti = 1'b0;
      @(posedge clk);
      @(negedge clk);
      tx_start = 1'b0; rd_rst = 1'b0; wr_en = 1'b0;
      k++;
    end
    chk("tx_end busy drop R4", busy, 0);
  endtask

  function automatic bit multi_exp(input int k);
    return (k < 4) ? 1'b1 : ((k < 6) ? 1'b0 : 1'b1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k, tn, tf, bad;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cfg_div = 8'd1; cfg_span = 2'd1; cfg_conti = 1'b0; cfg_lim = '0;
    cfg_car_en = 1'b0; cfg_car_on = 1'b1; cfg_car_hi = 16'd1; cfg_car_lo = 16'd1;
    cfg_idle_en = 1'b1; cfg_idle_lvl = 1'b1; tx_start = 1'b0; rd_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 tx_end", tx_end, 0);
    chk("R1 thr_evt", thr_evt, 0);
    chk("R1 idle pin", pin_out, 1);
    cfg_idle_lvl = 1'b0;

    // table of single-item runs: R2 R3 R4
    for (int i = 0; i < 5; i++) begin
      cfg_div = VEC[i][56:49];
      wr(0, VEC[i][48:17]);
      wr(1, 32'h0);
      ptr_rst();
      measure(-1, -1, -1, k, tn, tf);
      chk("R3 R4 edges to tx_end", k, int'(VEC[i][16:1]));
      if (VEC[i][16:1] != 0) chk("R2 first level", ptrace[0], VEC[i][0]);
    end

    // multi-item waveform: R2
    cfg_div = 8'd2;
    wr(0, 32'h0001_8002);
    wr(1, 32'h0000_8003);
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    chk("R2 multi total", k, 12);
    bad = 0;
    for (int j = 0; j < 12; j++) if (ptrace[j] != multi_exp(j)) bad++;
    chk("R2 multi waveform mismatches", bad, 0);
    // R5 idle behaviour
    chk("R5 idle level driven", pin_out, 0);
    @(negedge clk); cfg_idle_en = 1'b0;
    @(negedge clk);
    chk("R5 holds last level", pin_out, 1);
    cfg_idle_en = 1'b1;
    // R10 resume from the stop item
    measure(-1, -1, -1, k, tn, tf);
    chk("R10 resume without pointer reset", k, 6);
    // R11 start and pointer reset ignored while busy
    ptr_rst();
    measure(3, -1, -1, k, tn, tf);
    chk("R11 total with stray start", k, 12);
    bad = 0;
    for (int j = 0; j < 12; j++) if (ptrace[j] != multi_exp(j)) bad++;
    chk("R11 waveform mismatches", bad, 0);
    // R12 write during run to an item not yet reached
    ptr_rst();
    wr_addr = 7'd1; wr_data = 32'h0000_8005;
    measure(-1, 1, -1, k, tn, tf);
    chk("R12 write during run", k, 16);

    // R6 carrier
    cfg_div = 8'd1;
    wr(0, 32'h0002_8006);
    wr(1, 32'h0);
    cfg_car_en = 1'b1; cfg_car_on = 1'b1; cfg_car_hi = 16'd2; cfg_car_lo = 16'd1;
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    chk("R6 carrier total", k, 8);
    bad = 0;
    for (int j = 0; j < 8; j++)
      if (ptrace[j] != ((j < 6) ? (j % 3 != 2) : 1'b0)) bad++;
    chk("R6 carrier on high level", bad, 0);
    cfg_car_on = 1'b0;
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    bad = 0;
    for (int j = 0; j < 8; j++)
      if (ptrace[j] != ((j < 6) ? 1'b1 : (j % 3 != 2))) bad++;
    chk("R6 carrier on low level", bad, 0);
    cfg_car_en = 1'b0;

    // R7 threshold
    for (int j = 0; j < 5; j++) wr(j, 32'h0001_8001);
    wr(5, 32'h0);
    cfg_lim = 7'd3;
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    chk("R7 total unchanged", k, 10);
    chk("R7 event count", tn, 1);
    chk("R7 event step", tf, 6);
    cfg_lim = 7'd0;
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    chk("R7 disabled no event", tn, 0);

    // R8 span end in one-shot mode
    for (int j = 0; j < 128; j++) wr(j, 32'h0001_8001);
    ptr_rst();
    measure(-1, -1, -1, k, tn, tf);
    chk("R8 span 1", k, 128);
    measure(-1, -1, -1, k, tn, tf);
    chk("R8 pointer back at 0", k, 128);
    cfg_span = 2'd2;
    measure(-1, -1, -1, k, tn, tf);
    chk("R8 span 2", k, 256);
    cfg_span = 2'd0;
    measure(-1, -1, -1, k, tn, tf);
    chk("R8 span 0 as 1", k, 128);
    cfg_span = 2'd3;
    measure(-1, -1, -1, k, tn, tf);
    chk("R8 span clamps to 2", k, 256);

    // R9 continuous mode
    cfg_span = 2'd1;
    wr(5, 32'h0);
    cfg_conti = 1'b1;
    ptr_rst();
    measure(-1, -1, 25, k, tn, tf);
    chk("R9 wrap at terminator then stop", k, 30);
    wr(5, 32'h0001_8001);
    cfg_conti = 1'b1;
    ptr_rst();
    measure(-1, -1, 150, k, tn, tf);
    chk("R9 wrap at span end then stop", k, 256);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule